// File: doc/BRIEF.md
# Iterative Integer Multiply and Long Multiply Unit

This block executes the integer multiply group of a 32-bit processor core. A three-bit operation code selects one of five operations: a 32-bit product, a 32-bit product plus a 32-bit addend, an unsigned 32x32 to 64-bit product, a signed 32x32 to 64-bit product, and an unsigned 64-bit product plus a 64-bit addend. The 64-bit result leaves the block as a low word and a high word, meant for two destination registers. The three remaining codes are reported as undefined.

The issuing stage raises `start` for one cycle while `busy` is low. On that clock edge the block captures the operands, the addend words and the incoming carry and overflow flags. A radix-2 shift-add datapath then retires one multiplier bit per cycle. `done` pulses for one cycle when the result words and the carry, overflow, negative and zero flags are valid. The outputs keep those values until the next `done`.

Top module: `mul_long_unit`

## Requirements
- R1: Code 0 gives the low 32 bits of A*B on res_lo, and res_hi is 0.
- R2: Code 1 gives the low 32 bits of A*B + acc_lo on res_lo, and res_hi is 0.
- R3: Code 4 gives the unsigned 64-bit product A*B, with bits 31:0 on res_lo and bits 63:32 on res_hi.
- R4: Code 6 gives the 64-bit product of A and B taken as signed two's-complement values, split as in R3.
- R5: Code 7 gives (A*B + {acc_hi, acc_lo}) modulo 2^64, unsigned, split as in R3.
- R6: For codes 0 and 1, carry_out and ovf_out equal the carry_in and ovf_in values captured with start. For codes 4, 6 and 7, both are 1.
- R7: neg_out is bit 63 of the result for codes 4, 6 and 7, and bit 31 for codes 0 and 1. zero_out is 1 exactly when the whole written result is zero.
- R8: Codes 2, 3 and 5 set undef_out, leave both result words at 0 with zero_out 1 and neg_out 0, pass carry_in and ovf_in through, and pulse done in the cycle right after the capture edge with busy staying low.
- R9: For a defined code, busy is high from the capture edge until done, and done is a one-cycle pulse in the 32nd cycle after the capture edge, with busy low.
- R10: start is ignored while busy is high. All result and flag outputs hold their values between done pulses.
- R11: After reset, busy, done, undef_out and all result and flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (accepted when busy is low) |
| opcode | input | 3 | Operation code |
| op_a | input | 32 | Operand A (multiplicand) |
| op_b | input | 32 | Operand B (multiplier) |
| acc_lo | input | 32 | Low addend word (codes 1 and 7) |
| acc_hi | input | 32 | High addend word (code 7) |
| carry_in | input | 1 | Incoming carry flag |
| ovf_in | input | 1 | Incoming overflow flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results valid |
| res_lo | output | 32 | Low result word |
| res_hi | output | 32 | High result word |
| carry_out | output | 1 | Carry flag result |
| ovf_out | output | 1 | Overflow flag result |
| neg_out | output | 1 | Negative flag result |
| zero_out | output | 1 | Zero flag result |
| undef_out | output | 1 | Undefined code reported |

## Verification
Assertions in the checker check these on every cycle:
- the fixed latency of a defined operation and the immediate completion of an undefined one;
- that done never arrives while busy;
- the flag rules for the narrow and the wide forms, and the zero high word of the narrow forms;
- the agreement of the negative and zero flags with the result words;
- that the outputs hold between done pulses.

Only the bench scenarios can show that the arithmetic is right. Those scenarios are signed versus unsigned treatment of all-ones operands, the most negative operand squared, addend wrap-around past 2^64, and the ignoring of a start that arrives mid-operation.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

    typedef enum logic [2:0] {
        OP_MUL_LO    = 3'd0,
        OP_MAC_LO    = 3'd1,
        OP_RSV_2     = 3'd2,
        OP_RSV_3     = 3'd3,
        OP_UMUL_WIDE = 3'd4,
        OP_RSV_5     = 3'd5,
        OP_SMUL_WIDE = 3'd6,
        OP_UMAC_WIDE = 3'd7
    } mlu_op_e;

    // State captured with an accepted operation
    typedef struct packed {
        mlu_op_e op;
        logic    flip;   // negate the magnitude product at the end
        logic    cin;
        logic    vin;
    } mlu_job_t;

    // Flag bundle written with every completion
    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
        logic undef;
    } mlu_flags_t;

    function automatic logic op_is_wide(mlu_op_e op);
        return (op == OP_UMUL_WIDE) || (op == OP_SMUL_WIDE) || (op == OP_UMAC_WIDE);
    endfunction

    function automatic logic op_is_signed(mlu_op_e op);
        return op == OP_SMUL_WIDE;
    endfunction

    function automatic logic op_is_undef(mlu_op_e op);
        return (op == OP_RSV_2) || (op == OP_RSV_3) || (op == OP_RSV_5);
    endfunction

endpackage

// File: rtl/mlu_prep.sv
module mlu_prep
    import mlu_pkg::*;
#(
    parameter int W = 32
) (
    input  mlu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [W-1:0]     add_lo,
    input  logic [W-1:0]     add_hi,
    output logic [W-1:0]     mcand,
    output logic [W-1:0]     mplier,
    output logic [2*W-1:0]   acc_init,
    output logic             flip
);
    logic sgn;
    assign sgn = op_is_signed(op);

    always_comb begin
        // Signed mode works on magnitudes; the most negative value maps to 2^(W-1)
        mcand  = (sgn && a[W-1]) ? (~a + 1'b1) : a;
        mplier = (sgn && b[W-1]) ? (~b + 1'b1) : b;
        flip   = sgn && (a[W-1] ^ b[W-1]);
        unique case (op)
            OP_MAC_LO:    acc_init = {{W{1'b0}}, add_lo};
            OP_UMAC_WIDE: acc_init = {add_hi, add_lo};
            default:      acc_init = '0;
        endcase
    end
endmodule

// File: rtl/mlu_shift_add.sv
module mlu_shift_add #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    input  logic [W-1:0]     mcand_in,
    input  logic [W-1:0]     mplier_in,
    input  logic [2*W-1:0]   acc_init,
    output logic [2*W-1:0]   prod_next
);
    localparam int PW = 2 * W;

    logic [PW-1:0] part_q;
    logic [PW-1:0] mcand_q;
    logic [W-1:0]  mplier_q;

    // Sum after retiring the current multiplier bit
    assign prod_next = part_q + (mplier_q[0] ? mcand_q : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            part_q   <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            part_q   <= acc_init;
            mcand_q  <= {{W{1'b0}}, mcand_in};
            mplier_q <= mplier_in;
        end else if (step) begin
            part_q   <= prod_next;
            mcand_q  <= mcand_q << 1;
            mplier_q <= mplier_q >> 1;
        end
    end
endmodule

// File: rtl/mlu_finish.sv
module mlu_finish
    import mlu_pkg::*;
#(
    parameter int W = 32
) (
    input  mlu_job_t         job,
    input  logic [2*W-1:0]   prod,
    output logic [W-1:0]     lo,
    output logic [W-1:0]     hi,
    output mlu_flags_t       flags
);
    localparam int PW = 2 * W;

    logic [PW-1:0] full;
    logic          wide;

    assign full = job.flip ? (~prod + 1'b1) : prod;
    assign wide = op_is_wide(job.op);

    always_comb begin
        lo          = full[W-1:0];
        hi          = wide ? full[PW-1:W] : '0;
        flags.undef = 1'b0;
        if (wide) begin
            flags.c = 1'b1;
            flags.v = 1'b1;
            flags.n = full[PW-1];
            flags.z = (full == '0);
        end else begin
            flags.c = job.cin;
            flags.v = job.vin;
            flags.n = full[W-1];
            flags.z = (full[W-1:0] == '0);
        end
    end
endmodule

// File: rtl/mul_long_unit.sv
module mul_long_unit
    import mlu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    opcode,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic [W-1:0]  acc_lo,
    input  logic [W-1:0]  acc_hi,
    input  logic          carry_in,
    input  logic          ovf_in,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  res_lo,
    output logic [W-1:0]  res_hi,
    output logic          carry_out,
    output logic          ovf_out,
    output logic          neg_out,
    output logic          zero_out,
    output logic          undef_out
);
    localparam int PW = 2 * W;
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e           st_q;
    logic [CW-1:0] cnt_q;
    mlu_job_t      job_q;
    mlu_flags_t    flg_q;
    logic [W-1:0]  lo_q, hi_q;
    logic          done_q;

    mlu_op_e        op_in;
    logic           accept;
    logic           run;
    logic [W-1:0]   mcand, mplier;
    logic [PW-1:0]  acc_init, prod_next;
    logic           flip;
    logic [W-1:0]   fin_lo, fin_hi;
    mlu_flags_t     fin_flags;

    assign op_in  = mlu_op_e'(opcode);
    assign accept = (st_q == ST_IDLE) && start;
    assign run    = (st_q == ST_RUN);

    mlu_prep #(.W(W)) prep_i (
        .op       (op_in),
        .a        (op_a),
        .b        (op_b),
        .add_lo   (acc_lo),
        .add_hi   (acc_hi),
        .mcand    (mcand),
        .mplier   (mplier),
        .acc_init (acc_init),
        .flip     (flip)
    );

    mlu_shift_add #(.W(W)) eng_i (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .step      (run),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .acc_init  (acc_init),
        .prod_next (prod_next)
    );

    mlu_finish #(.W(W)) fin_i (
        .job   (job_q),
        .prod  (prod_next),
        .lo    (fin_lo),
        .hi    (fin_hi),
        .flags (fin_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            job_q  <= '0;
            flg_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                job_q <= '{op: op_in, flip: flip, cin: carry_in, vin: ovf_in};
                cnt_q <= '0;
                if (op_is_undef(op_in)) begin
                    lo_q   <= '0;
                    hi_q   <= '0;
                    flg_q  <= '{c: carry_in, v: ovf_in, n: 1'b0, z: 1'b1, undef: 1'b1};
                    done_q <= 1'b1;
                end else begin
                    st_q <= ST_RUN;
                end
            end else if (run) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    lo_q   <= fin_lo;
                    hi_q   <= fin_hi;
                    flg_q  <= fin_flags;
                    done_q <= 1'b1;
                    st_q   <= ST_IDLE;
                end
            end
        end
    end

    assign busy      = run;
    assign done      = done_q;
    assign res_lo    = lo_q;
    assign res_hi    = hi_q;
    assign carry_out = flg_q.c;
    assign ovf_out   = flg_q.v;
    assign neg_out   = flg_q.n;
    assign zero_out  = flg_q.z;
    assign undef_out = flg_q.undef;
endmodule

// File: rtl/mlu_checker.sv
module mlu_checker #(
    parameter int W = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic [2:0]    opcode,
    input logic          carry_in,
    input logic          ovf_in,
    input logic          busy,
    input logic          done,
    input logic [W-1:0]  res_lo,
    input logic [W-1:0]  res_hi,
    input logic          carry_out,
    input logic          ovf_out,
    input logic          neg_out,
    input logic          zero_out,
    input logic          undef_out
);
    logic [2:0]  cap_op;
    logic        cap_c, cap_v;
    logic [15:0] lat_cnt;
    logic        cap_wide;

    assign cap_wide = (cap_op == 3'd4) || (cap_op == 3'd6) || (cap_op == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_op  <= '0;
            cap_c   <= 1'b0;
            cap_v   <= 1'b0;
            lat_cnt <= '0;
        end else if (start && !busy) begin
            cap_op  <= opcode;
            cap_c   <= carry_in;
            cap_v   <= ovf_in;
            lat_cnt <= '0;
        end else if (busy) begin
            lat_cnt <= lat_cnt + 1'b1;
        end
    end

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                                   // R9
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (done && !undef_out) |-> (lat_cnt == 16'(W)));                     // R9
    AST_UNDEF_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (done && undef_out) |-> (lat_cnt == 16'd0 && res_lo == '0 && res_hi == '0)); // R8
    AST_WIDE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (done && !undef_out && cap_wide) |-> (carry_out && ovf_out));      // R6
    AST_NARROW_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (done && !undef_out && !cap_wide) |->
            (carry_out == cap_c && ovf_out == cap_v && res_hi == '0));     // R6
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |-> (zero_out == ({res_hi, res_lo} == '0)));                  // R7
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
        (done && !undef_out) |->
            (neg_out == (cap_wide ? res_hi[W-1] : res_lo[W-1])));          // R7
    AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(zero_out)
                   && $stable(undef_out)));                                // R10
endmodule

bind mul_long_unit mlu_checker #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .opcode    (opcode),
    .carry_in  (carry_in),
    .ovf_in    (ovf_in),
    .busy      (busy),
    .done      (done),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .carry_out (carry_out),
    .ovf_out   (ovf_out),
    .neg_out   (neg_out),
    .zero_out  (zero_out),
    .undef_out (undef_out)
);

// File: tb/mul_long_unit_tb_top.sv
`timescale 1ns/1ps
module mul_long_unit_tb_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [2:0]    opcode;
    logic [W-1:0]  op_a, op_b, acc_lo, acc_hi;
    logic          carry_in, ovf_in;
    logic          busy, done;
    logic [W-1:0]  res_lo, res_hi;
    logic          carry_out, ovf_out, neg_out, zero_out, undef_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mul_long_unit #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .op_a(op_a), .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
        .carry_in(carry_in), .ovf_in(ovf_in),
        .busy(busy), .done(done), .res_lo(res_lo), .res_hi(res_hi),
        .carry_out(carry_out), .ovf_out(ovf_out), .neg_out(neg_out),
        .zero_out(zero_out), .undef_out(undef_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: 64-bit result as the two destination words
    function automatic logic [63:0] ref_result(input logic [2:0] op, input logic [31:0] a,
            input logic [31:0] b, input logic [31:0] alo, input logic [31:0] ahi);
        longint unsigned ua, ub, r;
        longint sa, sb;
        ua = {32'd0, a};
        ub = {32'd0, b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            3'd0: r = {32'd0, 32'(ua * ub)};
            3'd1: r = {32'd0, 32'(ua * ub + {32'd0, alo})};
            3'd4: r = ua * ub;
            3'd6: r = longint'(sa * sb);
            3'd7: r = ua * ub + {ahi, alo};
            default: r = 64'd0;
        endcase
        return r;
    endfunction

    // Issue one operation and compare every cycle until it completes.
    // inj >= 0 drives a second start with other operands at that cycle.
    task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] alo, input logic [31:0] ahi,
                          input logic ci, input logic vi, input string req, input int inj);
        logic [63:0] exp_r;
        bit wide, undef;
        int lat;
        logic exp_n, exp_z, exp_c, exp_v;
        wide  = (op == 3'd4) || (op == 3'd6) || (op == 3'd7);
        undef = (op == 3'd2) || (op == 3'd3) || (op == 3'd5);
        exp_r = ref_result(op, a, b, alo, ahi);
        lat   = undef ? 0 : 32;
        exp_n = undef ? 1'b0 : (wide ? exp_r[63] : exp_r[31]);
        exp_z = (exp_r == 64'd0);
        exp_c = (wide && !undef) ? 1'b1 : ci;
        exp_v = (wide && !undef) ? 1'b1 : vi;

        @(negedge clk);
        opcode = op; op_a = a; op_b = b; acc_lo = alo; acc_hi = ahi;
        carry_in = ci; ovf_in = vi; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j <= lat; j++) begin
            if (j > 0) @(negedge clk);
            if (j == inj) begin
                opcode = 3'd4; op_a = ~a; op_b = 32'h1234_5678; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            check(done == (j == lat), "R9", $sformatf("done at cycle %0d", j), 64'(done), 64'(j == lat));
            check(busy == (j < lat), "R9", $sformatf("busy at cycle %0d", j), 64'(busy), 64'(j < lat));
        end
        check({res_hi, res_lo} == exp_r, req, "result", {res_hi, res_lo}, exp_r);
        check(undef_out == undef, "R8", "undef_out", 64'(undef_out), 64'(undef));
        check(carry_out == exp_c && ovf_out == exp_v, "R6", "carry/ovf",
              {62'd0, carry_out, ovf_out}, {62'd0, exp_c, exp_v});
        check(neg_out == exp_n && zero_out == exp_z, "R7", "neg/zero",
              {62'd0, neg_out, zero_out}, {62'd0, exp_n, exp_z});
        // Outputs must hold and no stray completion must follow
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(!done && !busy, "R10", "no extra completion", {62'd0, done, busy}, 64'd0);
        check({res_hi, res_lo} == exp_r, "R10", "result held", {res_hi, res_lo}, exp_r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; opcode = '0; op_a = '0; op_b = '0;
        acc_lo = '0; acc_hi = '0; carry_in = 1'b0; ovf_in = 1'b0;
        repeat (4) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !undef_out, "R11", "control after reset",
              {61'd0, busy, done, undef_out}, 64'd0);
        check({res_hi, res_lo} == 64'd0 && !carry_out && !ovf_out && !neg_out && !zero_out,
              "R11", "outputs after reset", {res_hi, res_lo}, 64'd0);
        rst = 1'b0;

        // R1 narrow product, flags pass through
        run_op(3'd0, 32'd7, 32'd9, 32'd0, 32'd0, 1'b1, 1'b0, "R1", -1);
        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, 1'b1, "R1", -1);
        run_op(3'd0, 32'h0001_0000, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 1'b1, "R1", -1);
        run_op(3'd0, 32'd0, 32'hDEAD_BEEF, 32'd0, 32'd0, 1'b0, 1'b0, "R7", -1);
        // R2 narrow accumulate, with wrap
        run_op(3'd1, 32'd1000, 32'd3000, 32'd55, 32'hAAAA_AAAA, 1'b1, 1'b0, "R2", -1);
        run_op(3'd1, 32'hFFFF_FFFF, 32'd1, 32'd1, 32'd0, 1'b0, 1'b1, "R2", -1);
        // R3 unsigned wide
        run_op(3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, 1'b0, "R3", -1);
        run_op(3'd4, 32'h1234_5678, 32'h9ABC_DEF0, 32'd0, 32'd0, 1'b0, 1'b0, "R3", -1);
        // R4 signed wide
        run_op(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 1'b0, 1'b0, "R4", -1);
        run_op(3'd6, 32'h8000_0000, 32'h8000_0000, 32'd0, 32'd0, 1'b0, 1'b0, "R4", -1);
        run_op(3'd6, 32'hFFFF_FFFE, 32'd12345, 32'd0, 32'd0, 1'b0, 1'b0, "R4", -1);
        run_op(3'd6, 32'd0, 32'h8000_0000, 32'd0, 32'd0, 1'b1, 1'b1, "R4", -1);
        // R5 unsigned wide accumulate, with wrap past 2^64
        run_op(3'd7, 32'd3, 32'd5, 32'hFFFF_FFFF, 32'd2, 1'b0, 1'b0, "R5", -1);
        run_op(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5", -1);
        run_op(3'd7, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, "R5", -1);
        // R8 undefined codes
        run_op(3'd2, 32'd5, 32'd6, 32'd0, 32'd0, 1'b1, 1'b0, "R8", -1);
        run_op(3'd3, 32'hFFFF_FFFF, 32'd2, 32'd0, 32'd0, 1'b0, 1'b1, "R8", -1);
        run_op(3'd5, 32'd11, 32'd13, 32'd1, 32'd1, 1'b1, 1'b1, "R8", -1);
        // R10 start while busy is ignored
        run_op(3'd4, 32'h0000_FFFF, 32'h0001_0001, 32'd0, 32'd0, 1'b0, 1'b0, "R10", 5);
        run_op(3'd0, 32'd6, 32'd7, 32'd0, 32'd0, 1'b1, 1'b0, "R10", 31);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule